// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Sequencer

This block sits inside an SDRAM memory controller. It decides when the SDRAM receives a refresh command or a low-power entry or exit sequence, and it drives the command pins and the clock-enable pin for those sequences. A four-bit control word chooses the behaviour: periodic auto-refresh, immediate self-refresh, or deep power-down. A low-frequency bit moves the launch of every command and the capture of read data onto the falling clock edge.

Periodic refresh is timed by an interval counter. The counter advances on ticks from a clock prescaler and wraps when it reaches a compare value, which leaves a refresh pending. Normal memory accesses are requested on a request/grant/done handshake. Every refresh or low-power sequence waits for the current access to finish, withholds new grants while it runs, and starts with a precharge-all command followed by a programmable wait.

Top module: `sdram_lp_ctrl`

## Requirements
- R1: With the enable bit (control bit 0) at 0, no precharge-all, auto-refresh, self-refresh or deep power-down command is issued whatever the other bits hold, and access requests are granted.
- R2: With enable 1 and mode (bit 1) at 0, auto-refresh commands (CS#, RAS#, CAS# low, WE# high, CKE high) recur every (ref_cmp+1)*(ref_psc+1) cycles while no access intervenes, and the deep bit (bit 2) has no effect. Only the encodings named in R2, R4, R5, R7 and NOP (CS# high) appear on the pins.
- R3: While acc_gnt is high the command pins show NOP. A pending refresh waits until the granted access signals acc_done, and no grant is given between a precharge-all and the command it prepares.
- R4: Every auto-refresh, self-refresh or deep power-down command is preceded by a precharge-all (CS#, RAS#, WE# low, CAS# high, CKE high) exactly t_prech+1 cycles earlier, with NOP in between.
- R5: A control write with enable 1, mode 1 and deep 0 leads to self-refresh entry (the auto-refresh encoding with CKE low) without waiting for the interval counter. Afterwards CKE stays low, the pins show NOP and no access is granted.
- R6: Clearing the mode bit during self-refresh raises CKE. For t_exit cycles, counting the cycle in which CKE rises, only NOP is shown and no grant is given. Grants resume after that.
- R7: A control write with enable 1, mode 1 and deep 1 leads to deep power-down entry (CS# and WE# low, RAS# and CAS# high, CKE low). CKE then stays low and no grant is given, even if the control bits change, until a reinit_req pulse releases it.
- R8: With the low-frequency bit (bit 3) at 1, the command and CKE pins change only at falling clock edges. With it at 0, they change only at rising edges.
- R9: rd_dout holds rd_din as sampled at the rising edge when the low-frequency bit is 0, and as sampled at the falling edge when it is 1.
- R10: During and right after reset the pins show NOP with CKE high, and acc_gnt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 4 | Control word: bit0 enable, bit1 mode, bit2 deep, bit3 low-frequency |
| ref_psc | input | PSC_W | Prescaler limit; one tick every ref_psc+1 cycles |
| ref_cmp | input | CNT_W | Interval compare value in ticks |
| t_prech | input | TW | NOP cycles after precharge-all |
| t_exit | input | TW | Exit-recovery cycles after self-refresh |
| acc_req | input | 1 | Normal access request |
| acc_done | input | 1 | Granted access has finished |
| acc_gnt | output | 1 | Access grant |
| reinit_req | input | 1 | Reinitialisation request that ends deep power-down |
| rd_din | input | DW | Read data from the SDRAM |
| rd_dout | output | DW | Captured read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |

## Verification
The hardest case to reach from the ports is a refresh that falls due while an access holds the grant. The pending flag has to wait on acc_done, and grants must stay blocked from the precharge until the refresh is issued. A long run with random request and hold lengths makes the interval counter's wrap land inside grants many times. A cycle monitor checks every sample for NOP under grant and for grants inside a sequence. Directed runs cover each of the eight enable/mode/deep combinations, self-refresh exit with a request already waiting, and deep power-down while the control bits are rewritten.

// File: rtl/sdrc_lp_pkg.sv
package sdrc_lp_pkg;

  // pin order: cs_n, ras_n, cas_n, we_n, cke
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic cke;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP     = 5'b11111;
  localparam sd_cmd_t CMD_NOP_LOW = 5'b11110;
  localparam sd_cmd_t CMD_PALL    = 5'b00101;
  localparam sd_cmd_t CMD_AREF    = 5'b00011;
  localparam sd_cmd_t CMD_SREF    = 5'b00010;
  localparam sd_cmd_t CMD_DPD     = 5'b01100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACC, ST_PRE, ST_PWAIT, ST_ISSUE, ST_SREF, ST_SXIT, ST_DPD
  } lp_state_t;

  typedef enum logic [1:0] {
    TG_AREF, TG_SREF, TG_DPD
  } lp_tgt_t;

endpackage

// File: rtl/sdrc_ref_timer.sv
module sdrc_ref_timer #(
  parameter int CNT_W = 12,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ack,
  input  logic [PSC_W-1:0] psc_lim,
  input  logic [CNT_W-1:0] cmp_val,
  output logic             pend
);

  logic [PSC_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             tick, hit;

  always_comb begin
    tick   = run && (psc_q == psc_lim);
    hit    = tick && (cnt_q == cmp_val);
    psc_d  = psc_q;
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (!run) begin
      psc_d  = '0;
      cnt_d  = '0;
      pend_d = 1'b0;
    end else begin
      psc_d = tick ? '0 : psc_q + 1'b1;
      if (hit)       cnt_d = '0;
      else if (tick) cnt_d = cnt_q + 1'b1;
      if (hit)       pend_d = 1'b1;
      else if (ack)  pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      psc_q  <= psc_d;
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R2
  wrap_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (psc_q == psc_lim) && (cnt_q == cmp_val)) |=> (pend_q && cnt_q == '0));

endmodule

// File: rtl/sdrc_lp_fsm.sv
module sdrc_lp_fsm
  import sdrc_lp_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          mode,
  input  logic          deep,
  input  logic          lp_req,
  input  logic          pend,
  input  logic          acc_req,
  input  logic          acc_done,
  input  logic          reinit,
  input  logic [TW-1:0] t_pre,
  input  logic [TW-1:0] t_exit,
  output sd_cmd_t       cmd,
  output logic          gnt,
  output logic          ref_ack,
  output logic          lp_ack,
  output logic          in_lp
);

  localparam logic [TW-1:0] ONE = TW'(1);

  lp_state_t     st_q, st_d;
  lp_tgt_t       tg_q, tg_d;
  logic [TW-1:0] cnt_q, cnt_d;

  // next state
  always_comb begin
    st_d    = st_q;
    tg_d    = tg_q;
    cnt_d   = cnt_q;
    ref_ack = 1'b0;
    lp_ack  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (lp_req && en) begin
          tg_d = deep ? TG_DPD : TG_SREF;
          st_d = ST_PRE;
        end else if (pend && en && !mode) begin
          tg_d = TG_AREF;
          st_d = ST_PRE;
        end else if (acc_req) begin
          st_d = ST_ACC;
        end
      end
      ST_ACC: if (acc_done) st_d = ST_IDLE;
      ST_PRE: begin
        cnt_d = t_pre;
        st_d  = (t_pre == '0) ? ST_ISSUE : ST_PWAIT;
      end
      ST_PWAIT: begin
        cnt_d = cnt_q - ONE;
        if (cnt_q == ONE) st_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        unique case (tg_q)
          TG_SREF: begin st_d = ST_SREF; lp_ack = 1'b1; end
          TG_DPD:  begin st_d = ST_DPD;  lp_ack = 1'b1; end
          default: begin st_d = ST_IDLE; ref_ack = 1'b1; end
        endcase
      end
      ST_SREF: begin
        if (!mode || !en) begin
          st_d  = ST_SXIT;
          cnt_d = (t_exit == '0) ? ONE : t_exit;
        end
      end
      ST_SXIT: begin
        cnt_d = cnt_q - ONE;
        if (cnt_q == ONE) st_d = ST_IDLE;
      end
      ST_DPD: if (reinit) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // command decode from current state
  always_comb begin
    unique case (st_q)
      ST_PRE:   cmd = CMD_PALL;
      ST_ISSUE: cmd = (tg_q == TG_SREF) ? CMD_SREF :
                      (tg_q == TG_DPD)  ? CMD_DPD  : CMD_AREF;
      ST_SREF, ST_DPD: cmd = CMD_NOP_LOW;
      default:  cmd = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tg_q  <= TG_AREF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      tg_q  <= tg_d;
      cnt_q <= cnt_d;
    end
  end

  assign gnt   = (st_q == ST_ACC);
  assign in_lp = (st_q == ST_SREF) || (st_q == ST_DPD);

  // R1
  off_no_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !en) |=> (st_q != ST_PRE));

  // R5
  sref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SREF && en && mode) |=> (st_q == ST_SREF));

  // R7
  dpd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DPD && !reinit) |=> (st_q == ST_DPD));

endmodule

// File: rtl/sdrc_cmd_launch.sv
module sdrc_cmd_launch
  import sdrc_lp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow,
  input  sd_cmd_t       cmd_in,
  input  logic [DW-1:0] rd_din,
  output sd_cmd_t       cmd_pos,
  output sd_cmd_t       cmd_out,
  output logic [DW-1:0] rd_dout
);

  sd_cmd_t       pos_q, neg_q;
  logic [DW-1:0] rdp_q, rdn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= CMD_NOP;
    else        pos_q <= cmd_in;
  end

  // half-cycle delayed copy for low-frequency launch
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= CMD_NOP;
    else        neg_q <= pos_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdp_q <= '0;
    else if (!slow) rdp_q <= rd_din;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)    rdn_q <= '0;
    else if (slow) rdn_q <= rd_din;
  end

  assign cmd_pos = pos_q;
  assign cmd_out = slow ? neg_q : pos_q;
  assign rd_dout = slow ? rdn_q : rdp_q;

  // R6
  cke_rise_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pos_q.cke) |-> pos_q.cs_n);

endmodule

// File: rtl/sdram_lp_ctrl.sv
module sdram_lp_ctrl
  import sdrc_lp_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PSC_W = 8,
  parameter int TW    = 4,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_wdata,
  input  logic [PSC_W-1:0] ref_psc,
  input  logic [CNT_W-1:0] ref_cmp,
  input  logic [TW-1:0]    t_prech,
  input  logic [TW-1:0]    t_exit,
  input  logic             acc_req,
  input  logic             acc_done,
  output logic             acc_gnt,
  input  logic             reinit_req,
  input  logic [DW-1:0]    rd_din,
  output logic [DW-1:0]    rd_dout,
  output logic             sd_cs_n,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic             sd_cke
);

  localparam int CFG_W = 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // control word and one-shot low-power request
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             lpr_q, lpr_d;
  logic             c_en, c_mode, c_deep, c_slow;
  logic             pend, ref_ack, lp_ack, in_lp, run;
  sd_cmd_t          fsm_cmd, cmd_pos, cmd_out;

  assign c_en   = cfg_q[0];
  assign c_mode = cfg_q[1];
  assign c_deep = cfg_q[2];
  assign c_slow = cfg_q[3];

  always_comb begin
    cfg_d = cfg_we ? cfg_wdata : cfg_q;
    lpr_d = lpr_q;
    if (cfg_we)      lpr_d = cfg_wdata[0] && cfg_wdata[1];
    else if (lp_ack) lpr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      lpr_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      lpr_q <= lpr_d;
    end
  end

  assign run = c_en && !c_mode && !in_lp;

  sdrc_ref_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_ni),
    .run     (run),
    .ack     (ref_ack),
    .psc_lim (ref_psc),
    .cmp_val (ref_cmp),
    .pend    (pend)
  );

  sdrc_lp_fsm #(.TW(TW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_ni),
    .en       (c_en),
    .mode     (c_mode),
    .deep     (c_deep),
    .lp_req   (lpr_q),
    .pend     (pend),
    .acc_req  (acc_req),
    .acc_done (acc_done),
    .reinit   (reinit_req),
    .t_pre    (t_prech),
    .t_exit   (t_exit),
    .cmd      (fsm_cmd),
    .gnt      (acc_gnt),
    .ref_ack  (ref_ack),
    .lp_ack   (lp_ack),
    .in_lp    (in_lp)
  );

  sdrc_cmd_launch #(.DW(DW)) u_launch (
    .clk     (clk),
    .rst_n   (rst_ni),
    .slow    (c_slow),
    .cmd_in  (fsm_cmd),
    .rd_din  (rd_din),
    .cmd_pos (cmd_pos),
    .cmd_out (cmd_out),
    .rd_dout (rd_dout)
  );

  assign sd_cs_n  = cmd_out.cs_n;
  assign sd_ras_n = cmd_out.ras_n;
  assign sd_cas_n = cmd_out.cas_n;
  assign sd_we_n  = cmd_out.we_n;
  assign sd_cke   = cmd_out.cke;

  // R3
  gnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_gnt |-> cmd_pos.cs_n);

endmodule

// File: tb/tb_sdram_lp_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_lp_ctrl;

  localparam int T_PRE  = 2;
  localparam int T_EXIT = 3;
  localparam int PSC    = 3;
  localparam int CMPV   = 9;
  localparam int PERIOD = (CMPV + 1) * (PSC + 1);

  localparam int K_NOP = 0, K_PALL = 1, K_AREF = 2, K_SREF = 3, K_DPD = 4, K_BAD = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_wdata;
  logic        acc_req, acc_done, reinit_req;
  logic [15:0] rd_din;
  logic        acc_gnt;
  logic [15:0] rd_dout;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke;

  always #2 clk = ~clk;

  sdram_lp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ref_psc(8'(PSC)), .ref_cmp(12'(CMPV)), .t_prech(4'(T_PRE)), .t_exit(4'(T_EXIT)),
    .acc_req(acc_req), .acc_done(acc_done), .acc_gnt(acc_gnt), .reinit_req(reinit_req),
    .rd_din(rd_din), .rd_dout(rd_dout),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_cke(sd_cke)
  );

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int decode(input logic [4:0] p);
    if (p[4]) return K_NOP;
    case (p)
      5'b00101: return K_PALL;
      5'b00011: return K_AREF;
      5'b00010: return K_SREF;
      5'b01100: return K_DPD;
      default:  return K_BAD;
    endcase
  endfunction

  // expected kind of sequence for a control combination
  function automatic int exp_kind(input bit en, input bit mode, input bit deep);
    if (!en) return K_NOP;
    if (!mode) return K_AREF;
    return deep ? K_DPD : K_SREF;
  endfunction

  // monitor state
  bit mon_en = 0, spacing_en = 0, in_seq = 0, lp = 0, lp_sref = 0, have_prev = 0;
  int cyc = 0, pall_cyc = 0, prev_aref = 0, exit_left = 0, exit_seen = 0;
  int n_pall = 0, n_aref = 0, n_sref = 0, n_dpd = 0, n_gnt = 0;
  bit track = 0;
  int rise_chg = 0, fall_chg = 0;
  logic [4:0] last_pins;

  function automatic logic [4:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke};
  endfunction

  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      int k;
      cyc++;
      k = decode(pins());
      if (k == K_BAD) chk(0, "R2 illegal encoding", int'(pins()), 31);
      if (lp && sd_cke) begin
        lp = 0;
        if (lp_sref) begin exit_left = T_EXIT; exit_seen++; end
      end
      if (exit_left > 0) begin
        chk(k == K_NOP && !acc_gnt, "R6 exit recovery quiet", k + 8 * int'(acc_gnt), K_NOP);
        exit_left--;
      end
      if (k == K_NOP && !sd_cke && !lp) chk(0, "R5 CKE low outside low-power", 0, 1);
      if (acc_gnt) begin
        n_gnt++;
        if (k != K_NOP) chk(0, "R3 pins not NOP under grant", k, K_NOP);
        if (in_seq) chk(0, "R3 grant inside sequence", 1, 0);
      end
      case (k)
        K_PALL: begin n_pall++; pall_cyc = cyc; in_seq = 1; end
        K_AREF, K_SREF, K_DPD: begin
          chk(in_seq && (cyc - pall_cyc == T_PRE + 1), "R4 precharge lead", cyc - pall_cyc, T_PRE + 1);
          in_seq = 0;
          if (k == K_AREF) begin
            n_aref++;
            if (spacing_en && have_prev) chk(cyc - prev_aref == PERIOD, "R2 refresh spacing", cyc - prev_aref, PERIOD);
            prev_aref = cyc; have_prev = 1;
          end else begin
            if (k == K_SREF) n_sref++; else n_dpd++;
            lp = 1; lp_sref = (k == K_SREF);
          end
        end
        default: ;
      endcase
      if (track) begin
        if (pins() != last_pins) fall_chg++;
      end
      last_pins = pins();
    end
  end

  always @(posedge clk) begin
    #1;
    if (mon_en && track && pins() != last_pins) rise_chg++;
    if (mon_en) last_pins = pins();
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic clear_stats();
    in_seq = 0; lp = 0; lp_sref = 0; have_prev = 0; exit_left = 0; exit_seen = 0;
    n_pall = 0; n_aref = 0; n_sref = 0; n_dpd = 0; n_gnt = 0;
  endtask

  task automatic do_reset();
    mon_en = 0;
    rst_n = 0; cfg_we = 0; cfg_wdata = '0; acc_req = 0; acc_done = 0; reinit_req = 0; rd_din = '0;
    repeat (3) step();
    rst_n = 1;
    repeat (3) step();
    clear_stats();
    mon_en = 1;
  endtask

  task automatic wr_cfg(input bit en, input bit mode, input bit deep, input bit lf);
    cfg_wdata = {lf, deep, mode, en};
    cfg_we = 1;
    step();
    cfg_we = 0;
  endtask

  task automatic finish_access();
    acc_done = 1; acc_req = 0;
    step();
    acc_done = 0;
  endtask

  initial begin
    void'($urandom(32'd4242));

    // R10 reset state
    rst_n = 0; cfg_we = 0; cfg_wdata = '0; acc_req = 0; acc_done = 0; reinit_req = 0; rd_din = '0;
    repeat (2) step();
    chk(pins() == 5'b11111, "R10 pins in reset", int'(pins()), 31);
    chk(!acc_gnt, "R10 grant in reset", int'(acc_gnt), 0);
    rst_n = 1;
    repeat (4) step();
    chk(pins() == 5'b11111, "R10 pins after reset", int'(pins()), 31);
    chk(!acc_gnt, "R10 grant after reset", int'(acc_gnt), 0);

    // all enable/mode/deep combinations (R1, R2, R5, R7)
    for (int c = 0; c < 8; c++) begin
      bit en, mode, deep;
      int ek;
      en = c[0]; mode = c[1]; deep = c[2];
      ek = exp_kind(en, mode, deep);
      do_reset();
      spacing_en = 1;
      wr_cfg(en, mode, deep, 0);
      repeat (150) step();
      spacing_en = 0;
      if (ek == K_NOP) chk(n_pall + n_aref + n_sref + n_dpd == 0, "R1 no sequence when disabled", n_pall + n_aref + n_sref + n_dpd, 0);
      if (ek == K_AREF) chk(n_aref >= 3 && n_sref + n_dpd == 0, "R2 auto-refresh only", n_aref, 3);
      if (ek == K_SREF) chk(n_sref == 1 && n_aref + n_dpd == 0 && !sd_cke, "R5 single self-refresh entry", n_sref, 1);
      if (ek == K_DPD) chk(n_dpd == 1 && n_aref + n_sref == 0 && !sd_cke, "R7 single deep power-down entry", n_dpd, 1);
      acc_req = 1;
      repeat (20) step();
      if (ek == K_SREF) chk(n_gnt == 0, "R5 no grant in self-refresh", n_gnt, 0);
      else if (ek == K_DPD) chk(n_gnt == 0, "R7 no grant in deep power-down", n_gnt, 0);
      else chk(n_gnt > 0, "R1 access granted", n_gnt, 1);
      finish_access();
    end

    // self-refresh entry latency and exit (R5, R6)
    do_reset();
    wr_cfg(1, 1, 0, 0);
    repeat (T_PRE + 5) step();
    chk(n_sref == 1, "R5 immediate self-refresh entry", n_sref, 1);
    repeat (10) step();
    acc_req = 1;
    repeat (10) step();
    wr_cfg(1, 0, 0, 0);
    repeat (20) step();
    chk(exit_seen == 1, "R6 CKE raised on exit", exit_seen, 1);
    chk(n_gnt > 0 && sd_cke, "R6 grants resume after recovery", n_gnt, 1);
    finish_access();

    // deep power-down holds until reinit (R7)
    do_reset();
    wr_cfg(1, 1, 1, 0);
    repeat (20) step();
    acc_req = 1;
    wr_cfg(1, 0, 1, 0);
    repeat (30) step();
    chk(!sd_cke, "R7 CKE stays low after control change", int'(sd_cke), 0);
    chk(n_gnt == 0, "R7 access refused", n_gnt, 0);
    reinit_req = 1;
    step();
    reinit_req = 0;
    repeat (10) step();
    chk(sd_cke == 1'b1, "R7 CKE high after reinit", int'(sd_cke), 1);
    chk(n_gnt > 0, "R7 grant after reinit", n_gnt, 1);
    finish_access();

    // random accesses against periodic refresh (R3)
    do_reset();
    wr_cfg(1, 0, 0, 0);
    begin
      int hold = 0;
      for (int i = 0; i < 3000; i++) begin
        if (acc_done) begin acc_done = 0; end
        else if (!acc_req) begin
          if ($urandom % 4 == 0) begin acc_req = 1; hold = $urandom % 16; end
        end else if (acc_gnt) begin
          if (hold == 0) begin acc_done = 1; acc_req = 0; end
          else hold--;
        end
        step();
      end
      acc_done = 0; acc_req = 0;
    end
    repeat (5) step();
    chk(n_aref > 0, "R3 refresh issued amid accesses", n_aref, 1);
    chk(n_gnt > 0, "R3 accesses granted amid refresh", n_gnt, 1);

    // launch edge selection (R8)
    do_reset();
    wr_cfg(1, 0, 0, 1);
    repeat (5) step();
    rise_chg = 0; fall_chg = 0; track = 1;
    repeat (200) step();
    track = 0;
    chk(rise_chg == 0, "R8 slow mode no rising-edge change", rise_chg, 0);
    chk(fall_chg > 0, "R8 slow mode falling-edge changes", fall_chg, 1);
    wr_cfg(1, 0, 0, 0);
    repeat (5) step();
    rise_chg = 0; fall_chg = 0; track = 1;
    repeat (200) step();
    track = 0;
    chk(fall_chg == 0, "R8 normal mode no falling-edge change", fall_chg, 0);
    chk(rise_chg > 0, "R8 normal mode rising-edge changes", rise_chg, 1);

    // read capture edge (R9)
    do_reset();
    for (int i = 0; i < 6; i++) begin
      bit lf;
      logic [15:0] xv, yv;
      lf = i[0];
      wr_cfg(0, 0, 0, lf);
      @(negedge clk); #0.5;
      xv = 16'($urandom); rd_din = xv;
      @(posedge clk); #0.5;
      yv = ~xv; rd_din = yv;
      @(negedge clk); #1.5;
      chk(rd_dout == (lf ? yv : xv), "R9 read capture edge", int'(rd_dout), int'(lf ? yv : xv));
      step();
    end

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule